// File: doc/BRIEF.md
# Memory Cycle Controller with Byte-Lane Strobes and Nonvolatile Write Guard

This block sits between an asynchronous 16-bit bus master with an address strobe, a read/write line and two data strobes (upper and lower byte), and a set of byte-wide memories. During an address-strobe-qualified cycle it decodes the address into one of four memory chip selects. It produces separate read and write strobes for each byte lane, and it answers the master with a data acknowledge that always comes one clock later than the shortest possible cycle. Addresses that hit no memory and no control register get a bus-error reply in place of the acknowledge.

Two regions hold nonvolatile contents: a calibration/compensation store and a battery-backed store of instrument settings. Writes to them are suppressed unless the matching bit of a write-only unlock register allows them. A suppressed write still receives its acknowledge, so the master never stalls. It also sets a sticky violation flag, which clears only on reset.

Top module: `mem_cycle_ctl`

## Requirements
- R1: While and after reset, `dtackN`, `berrN`, all chip selects and all four byte strobes are high (inactive), `writeViolation` is 0, and both unlock bits are clear, so both guarded regions start locked.
- R2: While `asN` is low, exactly the chip select of the region holding the byte address `{addr,0}` is low. The regions are ROM 0x000000–0x03FFFF (`romCsN`), calibration 0x040000–0x040FFF (`calCsN`), battery-backed 0x080000–0x087FFF (`bbramCsN`) and RAM 0x0C0000–0x0CFFFF (`ramCsN`). All chip selects are high when `asN` is high.
- R3: From the first rising edge at which `asN` is sampled low until `asN` rises, `rdUpperN` is low exactly when `rwN` is high, `udsN` is low and a memory region is hit. `rdLowerN` follows the same rule with `ldsN`.
- R4: In the same window, `wrUpperN` is low exactly when `rwN` is low, `udsN` is low, a memory region is hit and that region is not locked. `wrLowerN` follows the same rule with `ldsN`.
- R5: Every cycle has one wait state. The reply (`dtackN` or `berrN`) stays high after the first rising edge at which `asN` is sampled low and goes low after the second.
- R6: `dtackN` and `berrN` return high at the first rising edge at which `asN` is sampled high.
- R7: An address that hits no memory region and is not the unlock register gets `berrN` low instead of `dtackN`, with no chip select and no byte strobe. `dtackN` and `berrN` are never low together.
- R8: A write to the calibration region while unlock bit 0 is clear asserts no write strobe and still ends with `dtackN`.
- R9: A write to the battery-backed region while unlock bit 1 is clear asserts no write strobe and still ends with `dtackN`.
- R10: A write to the word at 0x0E0000 with `ldsN` low loads `dataIn[0]` (calibration enable) and `dataIn[1]` (battery-backed enable) at the acknowledge edge, and the new bits apply from the next cycle on. With `ldsN` high the register is unchanged. Reads and writes of this word get `dtackN`, with no chip select and no byte strobe.
- R11: A write suppressed under R8 or R9 with at least one data strobe low sets `writeViolation`, which then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 23 | Word address, byte address bits 23..1 |
| asN | input | 1 | Address strobe, active low |
| rwN | input | 1 | High for read, low for write |
| udsN | input | 1 | Upper byte data strobe, active low |
| ldsN | input | 1 | Lower byte data strobe, active low |
| dataIn | input | 2 | Data bus bits 1..0, used by unlock register writes |
| romCsN | output | 1 | ROM chip select, active low |
| calCsN | output | 1 | Calibration store chip select, active low |
| bbramCsN | output | 1 | Battery-backed store chip select, active low |
| ramCsN | output | 1 | General RAM chip select, active low |
| rdUpperN | output | 1 | Upper byte read strobe, active low |
| rdLowerN | output | 1 | Lower byte read strobe, active low |
| wrUpperN | output | 1 | Upper byte write strobe, active low |
| wrLowerN | output | 1 | Lower byte write strobe, active low |
| dtackN | output | 1 | Data acknowledge, active low |
| berrN | output | 1 | Bus error, active low |
| writeViolation | output | 1 | Sticky flag for a suppressed guarded write |

## Verification
The assertions assume that the inputs are already synchronous to `clk`. They also assume that `addr`, `rwN` and the data strobes stay stable while `asN` is low, and that `asN` stays low until a reply appears. The stimulus drives address, direction, strobes and `asN` together on a falling clock edge. It holds them until the bench sees `dtackN` or `berrN` low, and then raises `asN` and both data strobes together. Each cycle is followed by at least one idle clock, so every cycle starts from the idle state and a cycle is never abandoned before its reply.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int AddrW    = 24;
  localparam int NumMem   = 4;
  localparam int MemRom   = 0;
  localparam int MemCal   = 1;
  localparam int MemBbram = 2;
  localparam int MemRam   = 3;
  localparam int UnlockW  = 2;
  localparam logic [AddrW-1:0] UnlockAddr = 24'h0E0000;

  // region bases; each region is a power-of-two span aligned to its base
  function automatic logic [AddrW-1:0] memBase(input int idx);
    case (idx)
      MemRom:   memBase = 24'h000000;
      MemCal:   memBase = 24'h040000;
      MemBbram: memBase = 24'h080000;
      default:  memBase = 24'h0C0000;
    endcase
  endfunction

  function automatic logic [AddrW-1:0] memSpan(input int idx);
    case (idx)
      MemRom:   memSpan = 24'h040000;
      MemCal:   memSpan = 24'h001000;
      MemBbram: memSpan = 24'h008000;
      default:  memSpan = 24'h010000;
    endcase
  endfunction

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ACK
  } cycState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic busy;    // a cycle has been accepted and not yet closed
    logic commit;  // single-clock pulse at the acknowledge edge
  } ctlStrobes_t;
endpackage

// File: rtl/mcc_datapath.sv
module mcc_datapath
  import mcc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [AddrW-1:1]   addr,
  input  logic               asN,
  input  logic               rwN,
  input  logic               udsN,
  input  logic               ldsN,
  input  logic [UnlockW-1:0] dataIn,
  input  ctlStrobes_t        ctl,
  output logic [NumMem-1:0]  memCsN,
  output logic               rdUpperN,
  output logic               rdLowerN,
  output logic               wrUpperN,
  output logic               wrLowerN,
  output logic               unmapped,
  output logic               writeViolation
);
  logic [AddrW-1:0]   byteAddr;
  logic [NumMem-1:0]  memHit;
  logic               unlockHit;
  logic               anyMem;
  logic               writeOk;
  logic               laneWindow;
  logic               blockedWrite;
  logic [UnlockW-1:0] unlockQ;

  assign byteAddr = {addr, 1'b0};

  for (genvar g = 0; g < NumMem; g++) begin : gRegion
    assign memHit[g] = (byteAddr & ~(memSpan(g) - 1'b1)) == memBase(g);
  end

  assign unlockHit = addr == UnlockAddr[AddrW-1:1];
  assign anyMem    = |memHit;
  assign unmapped  = !anyMem && !unlockHit;
  assign memCsN    = ~(memHit & {NumMem{!asN}});

  // bit 0 guards the calibration store, bit 1 the battery-backed store
  assign writeOk = !(memHit[MemCal] && !unlockQ[0]) &&
                   !(memHit[MemBbram] && !unlockQ[1]);

  assign laneWindow = ctl.busy && !asN && anyMem;

  assign rdUpperN = !(laneWindow && rwN && !udsN);
  assign rdLowerN = !(laneWindow && rwN && !ldsN);
  assign wrUpperN = !(laneWindow && !rwN && writeOk && !udsN);
  assign wrLowerN = !(laneWindow && !rwN && writeOk && !ldsN);

  assign blockedWrite = laneWindow && !rwN && !writeOk && (!udsN || !ldsN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unlockQ        <= '0;
      writeViolation <= 1'b0;
    end else if (ctl.commit) begin
      if (unlockHit && !rwN && !ldsN) unlockQ <= dataIn;
      if (blockedWrite) writeViolation <= 1'b1;
    end
  end

  // R8: a locked calibration store never sees a write strobe
  assert_cal_guard_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN[MemCal] && !unlockQ[0]) |-> (wrUpperN && wrLowerN));

  // R9: same guard for the battery-backed store
  assert_bbram_guard_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN[MemBbram] && !unlockQ[1]) |-> (wrUpperN && wrLowerN));

  // R11: once set, the violation flag holds
  assert_violation_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    writeViolation |=> writeViolation);

  // R3: a lane is never read and written at once
  assert_lane_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !((!rdUpperN && !wrUpperN) || (!rdLowerN && !wrLowerN)));
endmodule

// File: rtl/mcc_control.sv
module mcc_control
  import mcc_pkg::*;
#(
  parameter int WaitStates = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        asN,
  input  logic        unmapped,
  output ctlStrobes_t ctl,
  output logic        dtackN,
  output logic        berrN
);
  localparam int CntW = $clog2(WaitStates + 1);

  cycState_t       state;
  logic [CntW-1:0] waitCnt;
  logic            lastWait;

  assign lastWait   = waitCnt == CntW'(WaitStates - 1);
  assign ctl.busy   = state != ST_IDLE;
  assign ctl.commit = (state == ST_WAIT) && !asN && lastWait;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      dtackN  <= 1'b1;
      berrN   <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!asN) begin
            state   <= ST_WAIT;
            waitCnt <= '0;
          end
        end
        ST_WAIT: begin
          if (asN) begin
            state <= ST_IDLE;
          end else if (lastWait) begin
            state  <= ST_ACK;
            dtackN <= unmapped;
            berrN  <= !unmapped;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_ACK: begin
          if (asN) begin
            state  <= ST_IDLE;
            dtackN <= 1'b1;
            berrN  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: acknowledge and bus error never overlap
  assert_reply_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(!dtackN && !berrN));

  // R6: a raised address strobe clears the reply on the next edge
  assert_reply_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    asN |=> (dtackN && berrN));

  // R5: an acknowledge follows at least two edges with the strobe low
  assert_wait_state_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dtackN) |-> (!$past(asN) && !$past(asN, 2)));
endmodule

// File: rtl/mem_cycle_ctl.sv
module mem_cycle_ctl
  import mcc_pkg::*;
#(
  parameter int WaitStates = 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [AddrW-1:1]   addr,
  input  logic               asN,
  input  logic               rwN,
  input  logic               udsN,
  input  logic               ldsN,
  input  logic [UnlockW-1:0] dataIn,
  output logic               romCsN,
  output logic               calCsN,
  output logic               bbramCsN,
  output logic               ramCsN,
  output logic               rdUpperN,
  output logic               rdLowerN,
  output logic               wrUpperN,
  output logic               wrLowerN,
  output logic               dtackN,
  output logic               berrN,
  output logic               writeViolation
);
  ctlStrobes_t       ctl;
  logic [NumMem-1:0] memCsN;
  logic              unmapped;

  mcc_control #(.WaitStates(WaitStates)) uControl (
    .clk      (clk),
    .rstN     (rstN),
    .asN      (asN),
    .unmapped (unmapped),
    .ctl      (ctl),
    .dtackN   (dtackN),
    .berrN    (berrN)
  );

  mcc_datapath uDatapath (
    .clk            (clk),
    .rstN           (rstN),
    .addr           (addr),
    .asN            (asN),
    .rwN            (rwN),
    .udsN           (udsN),
    .ldsN           (ldsN),
    .dataIn         (dataIn),
    .ctl            (ctl),
    .memCsN         (memCsN),
    .rdUpperN       (rdUpperN),
    .rdLowerN       (rdLowerN),
    .wrUpperN       (wrUpperN),
    .wrLowerN       (wrLowerN),
    .unmapped       (unmapped),
    .writeViolation (writeViolation)
  );

  assign romCsN   = memCsN[MemRom];
  assign calCsN   = memCsN[MemCal];
  assign bbramCsN = memCsN[MemBbram];
  assign ramCsN   = memCsN[MemRam];
endmodule

// File: tb/tb_mem_cycle_ctl.sv
`timescale 1ns/100ps
module tb_mem_cycle_ctl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:1] addr = '0;
  logic        asN = 1'b1, rwN = 1'b1, udsN = 1'b1, ldsN = 1'b1;
  logic [1:0]  dataIn = '0;
  logic romCsN, calCsN, bbramCsN, ramCsN;
  logic rdUpperN, rdLowerN, wrUpperN, wrLowerN;
  logic dtackN, berrN, writeViolation;

  always #2.5 clk = ~clk;

  mem_cycle_ctl dut (
    .clk(clk), .rstN(rstN), .addr(addr), .asN(asN), .rwN(rwN),
    .udsN(udsN), .ldsN(ldsN), .dataIn(dataIn),
    .romCsN(romCsN), .calCsN(calCsN), .bbramCsN(bbramCsN), .ramCsN(ramCsN),
    .rdUpperN(rdUpperN), .rdLowerN(rdLowerN), .wrUpperN(wrUpperN), .wrLowerN(wrLowerN),
    .dtackN(dtackN), .berrN(berrN), .writeViolation(writeViolation)
  );

  typedef struct {
    string      tag;
    logic [3:0] cs;    // {rom, cal, bbram, ram}, active low
    logic [3:0] strb;  // {rdU, rdL, wrU, wrL}, active low
    logic       berr;
  } exp_t;

  exp_t expQ[$];
  int   compared = 0;
  int   mismatched = 0;
  logic calUnl = 1'b0, bbUnl = 1'b0, expViol = 1'b0;
  bit   done = 1'b0;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busCycle(input logic [23:0] a, input logic rd, input logic u,
                          input logic l, input logic [1:0] d, input string tag);
    exp_t e;
    logic isRom, isCal, isBb, isRam, isUnl, mem, ok;
    int   n;
    isRom = a < 24'h040000;
    isCal = a >= 24'h040000 && a < 24'h041000;
    isBb  = a >= 24'h080000 && a < 24'h088000;
    isRam = a >= 24'h0C0000 && a < 24'h0D0000;
    isUnl = {a[23:1], 1'b0} == 24'h0E0000;
    mem   = isRom || isCal || isBb || isRam;
    ok    = !(isCal && !calUnl) && !(isBb && !bbUnl);
    e.tag  = tag;
    e.cs   = ~{isRom, isCal, isBb, isRam};
    e.strb = ~{mem && rd && u, mem && rd && l, mem && !rd && ok && u, mem && !rd && ok && l};
    e.berr = !(mem || isUnl);
    if (mem && !rd && !ok && (u || l)) expViol = 1'b1;
    expQ.push_back(e);
    addr = a[23:1]; rwN = rd; udsN = !u; ldsN = !l; dataIn = d; asN = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (dtackN && berrN && n < 20);
    asN = 1'b1; udsN = 1'b1; ldsN = 1'b1;
    if (isUnl && !rd && l) begin
      calUnl = d[0];
      bbUnl  = d[1];
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops expected items as cycles appear at the ports
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (rstN && !asN) begin
        if (expQ.size() == 0) begin
          check("R5 unexpected cycle", 8'd1, 8'd0);
        end else begin
          e = expQ.pop_front();
          check({e.tag, " R2 chip selects"}, {4'h0, romCsN, calCsN, bbramCsN, ramCsN}, {4'h0, e.cs});
          check({e.tag, " R3/R4 strobes"}, {4'h0, rdUpperN, rdLowerN, wrUpperN, wrLowerN}, {4'h0, e.strb});
          check({e.tag, " R5 wait state"}, {6'h0, dtackN, berrN}, 8'h03);
          @(posedge clk);
          #1;
          check({e.tag, " R5/R7 reply"}, {6'h0, dtackN, berrN}, e.berr ? 8'h02 : 8'h01);
          for (int k = 0; k < 30; k++) begin
            @(posedge clk);
            #1;
            if (asN) break;
          end
          check({e.tag, " R6 release"}, {2'h0, dtackN, berrN, rdUpperN, rdLowerN, wrUpperN, wrLowerN}, 8'h3F);
        end
      end
    end
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      finishRun();
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 reset outputs", {dtackN, berrN, romCsN, calCsN, bbramCsN, ramCsN, rdUpperN, rdLowerN}, 8'hFF);
    check("R1 reset strobes/flag", {5'h0, wrUpperN, wrLowerN, writeViolation}, 8'h06);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", {5'h0, dtackN, berrN, writeViolation}, 8'h06);

    busCycle(24'h000100, 1'b1, 1'b1, 1'b1, 2'b00, "R3 rom word read");
    busCycle(24'h03FFFE, 1'b1, 1'b0, 1'b1, 2'b00, "R2 rom top lower read");
    busCycle(24'h040000, 1'b1, 1'b1, 1'b0, 2'b00, "R2 cal base upper read");
    busCycle(24'h041000, 1'b1, 1'b1, 1'b1, 2'b00, "R7 above cal");
    busCycle(24'h0C0010, 1'b0, 1'b1, 1'b0, 2'b00, "R4 ram upper write");
    busCycle(24'h0CFFFE, 1'b0, 1'b0, 1'b1, 2'b00, "R4 ram top lower write");
    busCycle(24'h0D0000, 1'b0, 1'b1, 1'b1, 2'b00, "R7 unmapped write");
    check("R11 clear after legal writes", {7'h0, writeViolation}, {7'h0, expViol});

    busCycle(24'h040010, 1'b0, 1'b1, 1'b1, 2'b00, "R8 cal locked write");
    check("R11 set by cal block", {7'h0, writeViolation}, {7'h0, expViol});
    busCycle(24'h087FFE, 1'b1, 1'b1, 1'b1, 2'b00, "R2 bbram top read");
    busCycle(24'h080020, 1'b0, 1'b1, 1'b1, 2'b00, "R9 bbram locked write");

    busCycle(24'h0E0000, 1'b0, 1'b0, 1'b1, 2'b01, "R10 unlock cal");
    busCycle(24'h040010, 1'b0, 1'b1, 1'b1, 2'b00, "R10 cal unlocked write");
    busCycle(24'h080020, 1'b0, 1'b0, 1'b1, 2'b00, "R9 bbram still locked");
    busCycle(24'h0E0000, 1'b0, 1'b1, 1'b0, 2'b11, "R10 upper-only ignored");
    busCycle(24'h080000, 1'b0, 1'b1, 1'b0, 2'b00, "R10 bbram unchanged");
    busCycle(24'h040FFE, 1'b0, 1'b0, 1'b1, 2'b00, "R10 cal still open");
    busCycle(24'h0E0000, 1'b1, 1'b1, 1'b1, 2'b00, "R10 unlock read");
    busCycle(24'h0E0000, 1'b0, 1'b1, 1'b1, 2'b10, "R10 swap to bbram");
    busCycle(24'h040010, 1'b0, 1'b1, 1'b1, 2'b00, "R8 cal relocked");
    busCycle(24'h080020, 1'b0, 1'b1, 1'b1, 2'b00, "R9 bbram unlocked write");
    busCycle(24'h088000, 1'b1, 1'b1, 1'b1, 2'b00, "R7 above bbram");
    check("R11 still set", {7'h0, writeViolation}, {7'h0, expViol});
    check("R3 queue drained", 8'(expQ.size()), 8'd0);

    repeat (4) @(negedge clk);
    done = 1'b1;
    finishRun();
  end
endmodule